// File: doc/BRIEF.md
# Decade Result Counter with Holding Latch and Digit Scan

This block measures the de-integration phase of a dual-slope converter as a count of clock ticks. When a run-down start is seen while idle, a chain of cascaded decimal stages counts every enabled tick until zero-detect arrives. A carry out of the top stage sets an overrange digit. A second carry raises a count-extend flag for the phase sequencer and stops counting.

The finished count is copied into holding latches by an active-low transfer strobe. A separate active-low clear strobe empties the counters. The clear is honoured only after a fixed hold-off of clock cycles that follows the end of the transfer. The latched digits are presented one at a time as BCD with a digit-select code, from the most significant digit down to the least, for a multiplexed display. Seven-segment decoding is left to a downstream block.

The controller is a state machine with six named states. IDLE waits for run-down start. COUNT accumulates ticks. DONE holds the result. XFER is active while transfer is low. GUARD counts the hold-off. ARMED accepts a clear. The transitions are:
- IDLE→COUNT on run-down start.
- COUNT→DONE on zero-detect or on the second top carry.
- DONE, GUARD or ARMED→XFER on transfer low.
- XFER→GUARD on transfer high.
- GUARD→ARMED when the hold-off expires.
- ARMED→IDLE on clear low.

Top module: `bcd_tally`

## Requirements
- R1: After reset, `digit_sel` is 0, `digit_bcd` is 0, and `ovr_digit` and `count_ext` are 0.
- R2: A `rundown_start` pulse in IDLE enters COUNT. Each later cycle with `tick_en` high and `zero_det` low adds one to the decimal count. Cycles with `tick_en` low add nothing.
- R3: `zero_det` high in COUNT ends counting. Ticks and `rundown_start` pulses after that have no effect on the held count.
- R4: `xfer_n` low in DONE, XFER, GUARD or ARMED copies the counter digits and the overrange flag into the latches. At all other times the latched values stay unchanged, including while a new count is running.
- R5: `clr_n` low zeroes the counters, overrange and count-extend only in ARMED. ARMED is reached `HOLDOFF` cycles after `xfer_n` returns high. A `clr_n` low in GUARD or any other state is ignored.
- R6: The tick that carries out of the top decade (count 10^NDIG) sets the overrange flag, and the decades wrap to zero; `ovr_digit` shows the latched flag.
- R7: A second top carry (count 2·10^NDIG) sets `count_ext` and moves to DONE. Later ticks are ignored, overrange stays 1, and `count_ext` stays high until a clear.
- R8: `digit_sel` value k selects latched digit NDIG-1-k. Code 0 is the most significant digit and code NDIG-1 is the units. The code advances by one every `SCAN_DIV` cycles and wraps from NDIG-1 to 0.
- R9: Every counter digit and every `digit_bcd` value stays in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable tick |
| rundown_start | input | 1 | Start of de-integration |
| zero_det | input | 1 | Zero-detect from comparator logic |
| xfer_n | input | 1 | Active-low transfer to holding latches |
| clr_n | input | 1 | Active-low counter clear |
| digit_bcd | output | 4 | BCD value of the selected latched digit |
| digit_sel | output | SEL_W | Digit-select code, 0 = most significant |
| ovr_digit | output | 1 | Latched overrange digit |
| count_ext | output | 1 | Count-extend / overflow to the phase sequencer |

## Verification
The bench builds the block with four decades, a hold-off of 3 cycles and a scan divide of 3. With these values a full overflow run of 20,000 ticks fits easily in the run time. The short hold-off puts a clear attempt inside GUARD within reach of a single cycle. The short scan period lets every latched result be read back digit by digit in a few cycles. Counts of 12345 and 20003 drive the overrange and count-extend paths. Gapped ticks and pulses sent after zero-detect exercise the ignore rules.

// File: rtl/bcd_tally_pkg.sv
package bcd_tally_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_DONE,
        ST_XFER,
        ST_GUARD,
        ST_ARMED
    } tally_state_e;
endpackage

// File: rtl/bcd_decade.sv
module bcd_decade (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       inc,
    output logic [3:0] q,
    output logic       carry
);
    assign carry = inc && (q == 4'd9);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 4'd0;
        else if (clr)
            q <= 4'd0;
        else if (inc)
            q <= carry ? 4'd0 : q + 4'd1;
    end
endmodule

// File: rtl/digit_scan.sv
module digit_scan #(
    parameter int NDIG     = 4,
    parameter int SCAN_DIV = 4,
    parameter int SEL_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NDIG-1:0][3:0] digits,
    output logic [SEL_W-1:0]     sel,
    output logic [3:0]           bcd
);
    localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic             step;

    assign step = (int'(div_q) == SCAN_DIV - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            sel   <= '0;
        end else begin
            div_q <= step ? '0 : div_q + 1'b1;
            if (step)
                sel <= (int'(sel) == NDIG - 1) ? '0 : sel + 1'b1;
        end
    end

    always_comb begin
        bcd = 4'd0;
        for (int i = 0; i < NDIG; i++)
            if (sel == SEL_W'(i))
                bcd = digits[NDIG-1-i];
    end
endmodule

// File: rtl/bcd_tally.sv
module bcd_tally
    import bcd_tally_pkg::*;
#(
    parameter int  NDIG     = 4,
    parameter int  HOLDOFF  = 3,
    parameter int  SCAN_DIV = 4,
    localparam int SEL_W    = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             rundown_start,
    input  logic             zero_det,
    input  logic             xfer_n,
    input  logic             clr_n,
    output logic [3:0]       digit_bcd,
    output logic [SEL_W-1:0] digit_sel,
    output logic             ovr_digit,
    output logic             count_ext
);
    localparam int HOLD_W = $clog2(HOLDOFF + 1);

    tally_state_e         state_q, state_d;
    logic [HOLD_W-1:0]    hold_q;
    logic [NDIG-1:0][3:0] cnt;
    logic [NDIG-1:0][3:0] lat_q;
    logic [NDIG:0]        chain;
    logic                 ovr_q, cext_q, lat_ovr_q;
    logic                 do_count, do_clear, do_latch, top_carry;

    // Decade chain: each stage increments when all lower stages roll over.
    assign chain[0]  = do_count;
    assign top_carry = chain[NDIG];

    for (genvar g = 0; g < NDIG; g++) begin : g_dec
        bcd_decade u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (do_clear),
            .inc   (chain[g]),
            .q     (cnt[g]),
            .carry (chain[g+1])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rundown_start) state_d = ST_COUNT;
            ST_COUNT: if (zero_det || (top_carry && ovr_q)) state_d = ST_DONE;
            ST_DONE:  if (!xfer_n) state_d = ST_XFER;
            ST_XFER:  if (xfer_n) state_d = ST_GUARD;
            ST_GUARD: begin
                if (!xfer_n)
                    state_d = ST_XFER;
                else if (int'(hold_q) == HOLDOFF - 1)
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!xfer_n)
                    state_d = ST_XFER;
                else if (!clr_n)
                    state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        do_count = 1'b0;
        do_clear = 1'b0;
        do_latch = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_COUNT: do_count = tick_en && !zero_det;
            ST_DONE,
            ST_XFER,
            ST_GUARD: do_latch = !xfer_n;
            ST_ARMED: begin
                do_latch = !xfer_n;
                do_clear = xfer_n && !clr_n;
            end
            default:  ;
        endcase
    end

    // Hold-off counter, ovr/extend flags and holding latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            ovr_q     <= 1'b0;
            cext_q    <= 1'b0;
            lat_q     <= '0;
            lat_ovr_q <= 1'b0;
        end else begin
            hold_q <= (state_q == ST_GUARD && xfer_n) ? hold_q + 1'b1 : '0;
            if (do_clear) begin
                ovr_q  <= 1'b0;
                cext_q <= 1'b0;
            end else if (top_carry) begin
                if (ovr_q)
                    cext_q <= 1'b1;
                else
                    ovr_q <= 1'b1;
            end
            if (do_latch) begin
                lat_q     <= cnt;
                lat_ovr_q <= ovr_q;
            end
        end
    end

    digit_scan #(.NDIG(NDIG), .SCAN_DIV(SCAN_DIV), .SEL_W(SEL_W)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .digits (lat_q),
        .sel    (digit_sel),
        .bcd    (digit_bcd)
    );

    assign ovr_digit = lat_ovr_q;
    assign count_ext = cext_q;
endmodule

// File: rtl/bcd_tally_chk.sv
module bcd_tally_chk
    import bcd_tally_pkg::*;
#(
    parameter int NDIG  = 4,
    parameter int SEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_n,
    input logic              clr_n,
    input tally_state_e      state,
    input logic [4*NDIG-1:0] cnt_flat,
    input logic [4*NDIG-1:0] lat_flat,
    input logic              ovr,
    input logic              cext,
    input logic [3:0]        digit_bcd,
    input logic [SEL_W-1:0]  digit_sel
);
    function automatic logic all_decimal(input logic [4*NDIG-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NDIG; i++)
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [SEL_W-1:0] sel_after(input logic [SEL_W-1:0] s);
        return (int'(s) == NDIG - 1) ? '0 : s + 1'b1;
    endfunction

    // R4: latches only move on a transfer
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_n |=> $stable(lat_flat));

    // R5: counters frozen outside COUNT unless a clear is honoured in ARMED
    p_cnt_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COUNT && !(state == ST_ARMED && xfer_n && !clr_n)) |=> $stable(cnt_flat));

    // R5: no path back to IDLE from XFER or GUARD
    p_no_early_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER || state == ST_GUARD) |=> (state != ST_IDLE));

    // R7: count-extend only with overrange set
    p_ext_needs_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cext |-> ovr);

    // R8: scan code holds or steps by one with wrap
    p_scan_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) or 1'b1 |=> ($stable(digit_sel) || digit_sel == sel_after($past(digit_sel))));

    // R9: all digits decimal
    p_decimal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        all_decimal(cnt_flat) && (digit_bcd <= 4'd9));
endmodule

bind bcd_tally bcd_tally_chk #(.NDIG(NDIG), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_n    (xfer_n),
    .clr_n     (clr_n),
    .state     (state_q),
    .cnt_flat  (cnt),
    .lat_flat  (lat_q),
    .ovr       (ovr_q),
    .cext      (cext_q),
    .digit_bcd (digit_bcd),
    .digit_sel (digit_sel)
);

// File: tb/bcd_tally_bench.sv
module bcd_tally_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NDIG       = 4;
    localparam int HOLDOFF    = 3;
    localparam int SCAN_DIV   = 3;
    localparam int SEL_W      = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0, rundown_start = 1'b0, zero_det = 1'b0;
    logic             xfer_n = 1'b1, clr_n = 1'b1;
    logic [3:0]       digit_bcd;
    logic [SEL_W-1:0] digit_sel;
    logic             ovr_digit, count_ext;

    bcd_tally #(.NDIG(NDIG), .HOLDOFF(HOLDOFF), .SCAN_DIV(SCAN_DIV)) u_bcd_tally (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rundown_start(rundown_start),
        .zero_det(zero_det), .xfer_n(xfer_n), .clr_n(clr_n), .digit_bcd(digit_bcd),
        .digit_sel(digit_sel), .ovr_digit(ovr_digit), .count_ext(count_ext)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { int sel; int bcd; string tag; } scan_item_t;
    scan_item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pop expected digits as the scan presents them
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0 && int'(digit_sel) == sb_q[0].sel) begin
            check(sb_q[0].tag, int'(digit_bcd), sb_q[0].bcd);
            void'(sb_q.pop_front());
        end
    end

    // Driver: push expected scan items for a latched value (code 0 = MSD)
    task automatic expect_scan(input int value, input string tag);
        int p;
        for (int i = 0; i < NDIG; i++) begin
            p = 1;
            for (int k = 0; k < NDIG - 1 - i; k++) p = p * 10;
            sb_q.push_back('{sel: i, bcd: (value / p) % 10, tag: tag});
        end
        for (int k = 0; k < NDIG * SCAN_DIV * 3 && sb_q.size() > 0; k++)
            @(negedge clk);
        if (sb_q.size() > 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8 scan timeout: actual %0d pending expected 0", sb_q.size());
            sb_q.delete();
        end
    endtask

    task automatic measure(input int n, input bit gaps);
        @(negedge clk); rundown_start = 1'b1;
        @(negedge clk); rundown_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            if (gaps) begin
                tick_en = 1'b0;
                @(negedge clk);
            end
        end
        tick_en = 1'b0; zero_det = 1'b1;
        @(negedge clk); zero_det = 1'b0;
    endtask

    task automatic transfer();
        xfer_n = 1'b0;
        @(negedge clk); xfer_n = 1'b1;
    endtask

    task automatic clear();
        repeat (HOLDOFF + 2) @(negedge clk);
        clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int dwell;
        logic [SEL_W-1:0] s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 sel", int'(digit_sel), 0);
        check("R1 bcd", int'(digit_bcd), 0);
        check("R1 ovr", int'(ovr_digit), 0);
        check("R1 count_ext", int'(count_ext), 0);

        // R2 continuous ticks, R8 scan order
        measure(1234, 1'b0);
        transfer();
        expect_scan(1234, "R2/R8 count 1234");
        check("R6 no ovr at 1234", int'(ovr_digit), 0);
        // R8 dwell period
        s0 = digit_sel;
        while (digit_sel == s0) @(negedge clk);
        s0 = digit_sel; dwell = 0;
        while (digit_sel == s0) begin @(negedge clk); dwell++; end
        check("R8 dwell", dwell, SCAN_DIV);
        clear();

        // R2 gapped ticks
        measure(507, 1'b1);
        transfer();
        expect_scan(507, "R2 gapped 507");
        clear();

        // R3 ticks/start after zero-detect ignored; R5 clear in GUARD ignored
        measure(42, 1'b0);
        rundown_start = 1'b1; tick_en = 1'b1;
        repeat (5) @(negedge clk);
        rundown_start = 1'b0; tick_en = 1'b0;
        transfer();
        @(negedge clk);
        clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        transfer();
        expect_scan(42, "R3/R5 held 42");
        clear();

        // R4 latch unchanged while a new count runs, then reloads
        measure(7, 1'b1);
        expect_scan(42, "R4 latch kept");
        transfer();
        expect_scan(7, "R4 reload 7");
        clear();

        // R6 overrange
        measure(12345, 1'b0);
        transfer();
        @(negedge clk);
        check("R6 ovr_digit", int'(ovr_digit), 1);
        check("R7 no ext at 12345", int'(count_ext), 0);
        expect_scan(2345, "R6 wrapped 2345");
        clear();

        // R7 count-extend, counting stops at 2*10^NDIG
        measure(20003, 1'b0);
        check("R7 count_ext set", int'(count_ext), 1);
        transfer();
        @(negedge clk);
        check("R7 ovr kept", int'(ovr_digit), 1);
        expect_scan(0, "R7 stopped 0000");
        clear();
        check("R5/R7 ext cleared", int'(count_ext), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule